// File: doc/BRIEF.md
# Flash bank address translator

This block turns a linear byte offset into the 24-bit address that a serial NOR flash larger than 16 MiB accepts, together with the bank number that must sit in the device's extended-address register for that address to land in the right place. It also handles two-die arrangements. In a stacked pair, the upper half of the space is routed to the second die. In a parallel pair, both dies share every address and each holds half of each word.

A controller presents a request with an offset and a length, along with the total array size, the die arrangement and the read opcode. The block keeps a copy of the bank currently loaded in the device. It requests a bank-register write only when the new request needs a different bank, and it waits for that write to be acknowledged before presenting the result. The result is the device address, the upper-die flag, a four-byte command header and the length clipped so that one burst never crosses a bank edge. The controller sends the remainder as further requests. At start-up the cached bank is seeded from a value read back from the device, or forced to zero for small arrays.

Top module: `flash_bank_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `bank_wr_req` are 0, and the cached bank is 0, so a first request in bank 0 issues no bank write.
- R2: Mode encoding is 0 = single, 1 = stacked, 2 = parallel (3 behaves as single). In single mode the device address is the offset, `rsp_addr` is its low 24 bits, the bank is offset bits 31:24, and `rsp_upper` is 0.
- R3: In stacked mode, an offset at or above half of `cfg_size` has half the size subtracted and sets `rsp_upper`. Below that boundary the offset passes unchanged and `rsp_upper` is 0. The bank is taken from the remapped address.
- R4: In parallel mode the device address is the offset shifted right by one, so the bank is offset bits 31:25.
- R5: A bank write is requested only when the computed bank differs from the cached bank. Every accepted request stores its bank in the cache.
- R6: `bank_wr_req` stays high, with a stable value and opcode, until `bank_wr_ack` is sampled high. `rsp_valid` rises in the cycle after that acknowledgement. With no bank change it rises in the cycle after acceptance. It lasts one cycle, and `req_ready` is low from acceptance until `rsp_valid` has dropped.
- R7: `bank_wr_op` is `OP_BANK_WR_A` (default 0xC5) when `cfg_opsel` is 0 and `OP_BANK_WR_B` (default 0x17) when it is 1.
- R8: `rsp_len` is the smaller of the requested length and the distance from the offset to the end of its bank. A bank spans 16 MiB of offset, or 32 MiB in parallel mode. In stacked mode the distance is measured on the remapped address.
- R9: An `init_valid` pulse while idle with no request loads the cached bank from `init_bank` when `cfg_size` exceeds 16 MiB, and loads 0 otherwise.
- R10: `rsp_frame` carries the read opcode in bits 31:24, followed by device address bits 23:16, 15:8 and 7:0, most significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Die arrangement: 0 single, 1 stacked, 2 parallel |
| cfg_size | input | 32 | Total array size in bytes |
| cfg_opsel | input | 1 | Selects the bank-register write opcode |
| cfg_rd_opcode | input | 8 | Read opcode placed in the command header |
| init_valid | input | 1 | Seeds the cached bank |
| init_bank | input | 8 | Bank value read back from the device |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_offset | input | 32 | Linear byte offset |
| req_len | input | 32 | Requested length in bytes |
| req_ready | output | 1 | Block idle and able to take a request |
| bank_wr_req | output | 1 | Bank-register write wanted, held until acknowledged |
| bank_wr_val | output | 8 | New bank value |
| bank_wr_op | output | 8 | Opcode for the bank-register write |
| bank_wr_ack | input | 1 | Bank-register write finished |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_addr | output | 24 | Device address |
| rsp_upper | output | 1 | Upper die selected (stacked mode) |
| rsp_len | output | 32 | Length clipped at the bank edge |
| rsp_frame | output | 32 | Opcode byte followed by three address bytes |

## Verification
A request is taken at the clock edge where `req_valid` and `req_ready` are both high. The design registers the result at that same edge, so either `bank_wr_req` or `rsp_valid` is already up one cycle later. When a bank write is needed, `rsp_valid` follows exactly one cycle after the edge that samples `bank_wr_ack`. The bench drives and samples on falling edges and counts those edges explicitly. It also holds the acknowledgement back for several cycles to confirm that no result leaks out early. The bank cache has no output of its own, so its contents are observed through whether a later request raises `bank_wr_req`.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    localparam int AW       = 32;          // offset / size width
    localparam int BANK_LSB = 24;          // 16 MiB bank
    localparam int BW       = AW - BANK_LSB;
    localparam int LW       = 32;          // length width
    localparam int DW       = AW + 2;      // wide arithmetic for bank edges

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_STACKED  = 2'd1,
        MODE_PARALLEL = 2'd2
    } die_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BANKWR = 2'd1,
        ST_RESP   = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic [AW-1:0] dev;
        logic          upper;
        logic [BW-1:0] bank;
        logic [LW-1:0] len;
    } xl_t;

    function automatic xl_t translate(input logic [1:0] mode,
                                      input logic [AW-1:0] off,
                                      input logic [LW-1:0] len,
                                      input logic [AW-1:0] size);
        xl_t           r;
        logic [AW-1:0] half;
        logic [AW-1:0] lin;
        logic [DW-1:0] edge_v;
        logic [DW-1:0] remain;
        int            span;
        half    = size >> 1;
        r.dev   = off;
        r.upper = 1'b0;
        lin     = off;
        span    = BANK_LSB;
        case (mode)
            MODE_STACKED: begin
                if (off >= half) begin
                    r.dev   = off - half;
                    r.upper = 1'b1;
                end
                lin = r.dev;
            end
            MODE_PARALLEL: begin
                r.dev = off >> 1;
                span  = BANK_LSB + 1;
            end
            default: ;
        endcase
        r.bank = r.dev[AW-1:BANK_LSB];
        edge_v = DW'(r.bank) + DW'(1);
        edge_v = edge_v << span;
        remain = edge_v - DW'(lin);
        r.len  = (DW'(len) < remain) ? len : remain[LW-1:0];
        return r;
    endfunction

endpackage

// File: rtl/fbt_xlate.sv
module fbt_xlate
    import fbt_pkg::*;
(
    input  logic [1:0]    mode,
    input  logic [AW-1:0] off,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] size,
    output xl_t           xl
);
    always_comb xl = translate(mode, off, len, size);
endmodule

// File: rtl/fbt_bank_cache.sv
module fbt_bank_cache
    import fbt_pkg::*;
#(
    parameter logic [AW-1:0] SMALL_LIMIT = AW'(1) << BANK_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    input  logic [AW-1:0] size,
    input  logic          upd,
    input  logic [BW-1:0] upd_val,
    output logic [BW-1:0] cur
);
    logic [BW-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (upd)
            cur_q <= upd_val;
        else if (load)
            cur_q <= (size > SMALL_LIMIT) ? load_val : '0;
    end

    assign cur = cur_q;
endmodule

// File: rtl/fbt_ctrl.sv
module fbt_ctrl
    import fbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic need_wr,
    input  xl_t  xl_in,
    input  logic wr_ack,
    output logic accept,
    output logic idle,
    output logic wr_req,
    output logic rsp_valid,
    output xl_t  xl_q
);
    xl_state_e st_q;

    assign idle      = (st_q == ST_IDLE);
    assign accept    = idle && req_valid;
    assign wr_req    = (st_q == ST_BANKWR);
    assign rsp_valid = (st_q == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            xl_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    xl_q <= xl_in;
                    st_q <= need_wr ? ST_BANKWR : ST_RESP;
                end
                ST_BANKWR: if (wr_ack) st_q <= ST_RESP;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_bank_xlate.sv
module flash_bank_xlate
    import fbt_pkg::*;
#(
    parameter logic [7:0] OP_BANK_WR_A = 8'hC5,
    parameter logic [7:0] OP_BANK_WR_B = 8'h17
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_mode,
    input  logic [31:0] cfg_size,
    input  logic        cfg_opsel,
    input  logic [7:0]  cfg_rd_opcode,
    input  logic        init_valid,
    input  logic [7:0]  init_bank,
    input  logic        req_valid,
    input  logic [31:0] req_offset,
    input  logic [31:0] req_len,
    output logic        req_ready,
    output logic        bank_wr_req,
    output logic [7:0]  bank_wr_val,
    output logic [7:0]  bank_wr_op,
    input  logic        bank_wr_ack,
    output logic        rsp_valid,
    output logic [23:0] rsp_addr,
    output logic        rsp_upper,
    output logic [31:0] rsp_len,
    output logic [31:0] rsp_frame
);
    xl_t           xl_c;
    xl_t           xl_q;
    logic [BW-1:0] cur_bank;
    logic          accept;
    logic          idle;

    fbt_xlate u_xlate (
        .mode (cfg_mode),
        .off  (req_offset),
        .len  (req_len),
        .size (cfg_size),
        .xl   (xl_c)
    );

    fbt_bank_cache u_cache (
        .clk      (clk),
        .rst      (rst),
        .load     (init_valid && idle && !req_valid),
        .load_val (init_bank),
        .size     (cfg_size),
        .upd      (accept),
        .upd_val  (xl_c.bank),
        .cur      (cur_bank)
    );

    fbt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .need_wr   (xl_c.bank != cur_bank),
        .xl_in     (xl_c),
        .wr_ack    (bank_wr_ack),
        .accept    (accept),
        .idle      (idle),
        .wr_req    (bank_wr_req),
        .rsp_valid (rsp_valid),
        .xl_q      (xl_q)
    );

    assign req_ready   = idle;
    assign bank_wr_val = xl_q.bank;
    assign bank_wr_op  = cfg_opsel ? OP_BANK_WR_B : OP_BANK_WR_A;
    assign rsp_addr    = xl_q.dev[BANK_LSB-1:0];
    assign rsp_upper   = xl_q.upper;
    assign rsp_len     = xl_q.len;
    assign rsp_frame   = {cfg_rd_opcode, xl_q.dev[23:16], xl_q.dev[15:8], xl_q.dev[7:0]};
endmodule

// File: rtl/flash_bank_xlate_chk.sv
module flash_bank_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_mode,
    input logic        req_ready,
    input logic        bank_wr_req,
    input logic [7:0]  bank_wr_val,
    input logic        bank_wr_ack,
    input logic        rsp_valid,
    input logic        rsp_upper,
    input logic [31:0] rsp_len
);
    // R6: write request held, value stable, until acknowledged
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        bank_wr_req && !bank_wr_ack |=> bank_wr_req && $stable(bank_wr_val));

    // R6: result follows the acknowledgement by one cycle
    p_rsp_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        bank_wr_req && bank_wr_ack |=> rsp_valid);

    // R6: result strobe lasts one cycle
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6: never a result while a bank write is pending
    p_no_early_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        bank_wr_req |-> !rsp_valid);

    // R6: idle excludes both outstanding strobes
    p_ready_excl_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bank_wr_req && !rsp_valid);

    // R3: upper die only in stacked mode
    p_upper_mode_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && cfg_mode != 2'd1 |-> !rsp_upper);

    // R8: a burst never exceeds the widest bank span
    p_len_bound_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_len <= 32'h0200_0000);
endmodule

bind flash_bank_xlate flash_bank_xlate_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_mode    (cfg_mode),
    .req_ready   (req_ready),
    .bank_wr_req (bank_wr_req),
    .bank_wr_val (bank_wr_val),
    .bank_wr_ack (bank_wr_ack),
    .rsp_valid   (rsp_valid),
    .rsp_upper   (rsp_upper),
    .rsp_len     (rsp_len)
);

// File: tb/flash_bank_xlate_tb_top.sv
`timescale 1ns/1ps
module flash_bank_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic [31:0] cfg_size = 32'h0400_0000;
    logic        cfg_opsel = 1'b0;
    logic [7:0]  cfg_rd_opcode = 8'h0B;
    logic        init_valid = 1'b0;
    logic [7:0]  init_bank = 8'h00;
    logic        req_valid = 1'b0;
    logic [31:0] req_offset = '0;
    logic [31:0] req_len = '0;
    logic        req_ready, bank_wr_req, bank_wr_ack = 1'b0;
    logic [7:0]  bank_wr_val, bank_wr_op;
    logic        rsp_valid, rsp_upper;
    logic [23:0] rsp_addr;
    logic [31:0] rsp_len, rsp_frame;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_bank_xlate dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One request; checks write handshake (if expected) and result.
    task automatic run_req(input string tag, input logic [31:0] off, input logic [31:0] len,
                           input bit exp_wr, input logic [7:0] exp_bank, input logic [7:0] exp_op,
                           input logic [23:0] exp_addr, input bit exp_up, input logic [31:0] exp_len);
        @(negedge clk);
        req_valid = 1'b1; req_offset = off; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R6 busy"}, 32'(req_ready), 32'd0);
        chk(bank_wr_req == exp_wr, {tag, " R5 bank write wanted"}, 32'(bank_wr_req), 32'(exp_wr));
        if (exp_wr) begin
            chk(bank_wr_val == exp_bank, {tag, " R5 bank value"}, 32'(bank_wr_val), 32'(exp_bank));
            chk(bank_wr_op == exp_op, {tag, " R7 opcode"}, 32'(bank_wr_op), 32'(exp_op));
            repeat (3) begin
                @(negedge clk);
                chk(bank_wr_req && !rsp_valid, {tag, " R6 held, no result"}, {bank_wr_req, rsp_valid}, 32'd2);
            end
            bank_wr_ack = 1'b1;
            @(negedge clk);
            bank_wr_ack = 1'b0;
        end
        chk(rsp_valid == 1'b1, {tag, " R6 result strobe"}, 32'(rsp_valid), 32'd1);
        chk(rsp_addr == exp_addr, {tag, " R2 address"}, 32'(rsp_addr), 32'(exp_addr));
        chk(rsp_upper == exp_up, {tag, " R3 upper"}, 32'(rsp_upper), 32'(exp_up));
        chk(rsp_len == exp_len, {tag, " R8 length"}, rsp_len, exp_len);
        chk(rsp_frame == {cfg_rd_opcode, exp_addr}, {tag, " R10 frame"}, rsp_frame, {cfg_rd_opcode, exp_addr});
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R6 back to idle"}, {rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic do_init(input logic [31:0] size, input logic [7:0] val);
        cfg_size = size;
        @(negedge clk);
        init_valid = 1'b1; init_bank = val;
        @(negedge clk);
        init_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(!rsp_valid && !bank_wr_req, "R1 strobes low", {bank_wr_req, rsp_valid}, 32'd0);
        run_req("R1 cache zero", 32'h0000_0040, 32'h8, 0, 8'h0, 8'h0, 24'h000040, 0, 32'h8);
    endtask

    task automatic t_single;
        cfg_mode = 2'd0; cfg_opsel = 1'b0;
        run_req("R2 single", 32'h0123_4567, 32'h100, 1, 8'h01, 8'hC5, 24'h234567, 0, 32'h100);
        run_req("R5 skip R8 clip", 32'h01FF_FFF0, 32'h40, 0, 8'h0, 8'h0, 24'hFFFFF0, 0, 32'h10);
    endtask

    task automatic t_stacked;
        cfg_mode = 2'd1; cfg_opsel = 1'b1;
        run_req("R3 stacked hi R7", 32'h0280_0000, 32'h20, 1, 8'h00, 8'h17, 24'h800000, 1, 32'h20);
        run_req("R3 stacked lo", 32'h0010_0000, 32'h8, 0, 8'h0, 8'h0, 24'h100000, 0, 32'h8);
    endtask

    task automatic t_parallel;
        cfg_mode = 2'd2; cfg_opsel = 1'b0;
        run_req("R4 parallel", 32'h0300_0004, 32'h100, 1, 8'h01, 8'hC5, 24'h800002, 0, 32'h100);
        run_req("R4 R8 parallel clip", 32'h03FF_FFF8, 32'h100, 0, 8'h0, 8'h0, 24'hFFFFFC, 0, 32'h8);
    endtask

    task automatic t_init;
        cfg_mode = 2'd0;
        do_init(32'h0100_0000, 8'h05);
        run_req("R9 small forces 0", 32'h0000_0010, 32'h4, 0, 8'h0, 8'h0, 24'h000010, 0, 32'h4);
        do_init(32'h0400_0000, 8'h03);
        run_req("R9 large loads", 32'h0312_0000, 32'h4, 0, 8'h0, 8'h0, 24'h120000, 0, 32'h4);
        run_req("R9 R5 leave bank", 32'h0012_0000, 32'h4, 1, 8'h00, 8'hC5, 24'h120000, 0, 32'h4);
    endtask

    initial begin
        t_reset();
        t_single();
        t_stacked();
        t_parallel();
        t_init();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule